// File: doc/BRIEF.md
# Prescaled Watchdog Timer

A watchdog timer that software reaches through a small word-addressed register bus. A 16-bit down-counter is stepped by a tick made in two stages: a programmable prescale stage that divides the clock by 1 to 256, followed by a fixed power-of-two divider that divides by 16, 32, 64 or 128. When a tick arrives while the counter already reads zero, the timer expires. On expiry the counter reloads from a reload register, and the timer can raise a level interrupt, request a system reset, both, or neither.

Software arms the timer in three writes. It writes the reload value, writes the same value into the count register, and then writes the control word with the run bit set. While the timer runs, software keeps it from expiring by writing the count register again, which is the kick. A pending interrupt stays set until software writes anything to the clear register. The reset request is a pulse of a fixed number of clock cycles that the system reset logic picks up.

Top module: `wdg_top`

## Requirements
- R1: After reset the control register reads 0x0001 (reset request enabled, timer stopped, divider select 0, prescale 0), the reload and count registers both read 0x8000, and irq_o and rst_req_o are low.
- R2: Register word addresses are 0 for control, 1 for reload, 2 for count and 3 for interrupt clear. The control fields are: bit 0 reset-request enable, bit 2 interrupt enable, bits [4:3] divider select, bit 5 run, bits [15:8] prescale. Control bits 1, 6 and 7 read back as zero whatever was written to them.
- R3: While running, one tick occurs every (prescale+1) x (16 << select) clock cycles. Select 0 gives a divider of 16, 1 gives 32, 2 gives 64 and 3 gives 128.
- R4: A tick decrements a non-zero count by one. A tick at count zero is an expiry, and it loads the reload value into the count.
- R5: A write to word 2 loads the written value into the count on that clock edge. The write takes priority over a tick on the same edge, and no expiry occurs on that edge.
- R6: An expiry with interrupt enable set makes irq_o high from the next cycle. irq_o stays high until any write to word 3, whatever the data. If a clear and a new expiry fall on the same edge, the expiry wins.
- R7: An expiry with reset-request enable set drives rst_req_o high for exactly RST_CYC cycles, starting the cycle after the expiry. An expiry during a pulse restarts the pulse at full length.
- R8: With the run bit clear, the count, the prescale stage and the divider stage all hold their values. Setting run again resumes counting from the held state.
- R9: A read of word 3 returns zero and changes nothing. A write to word 3 changes no register other than the pending interrupt.
- R10: An expiry with both enables clear reloads the count and leaves irq_o and rst_req_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and the counter |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; bus_rdata is valid in the same cycle |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data; zero when bus_rd is low |
| irq_o | output | 1 | Pending expiry interrupt (level) |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
The assertions assume that the bus never raises bus_wr and bus_rd in the same cycle, and that each strobe lasts one cycle per access. The bench drives every access from the falling clock edge as a single-cycle strobe with idle cycles between accesses, so both assumptions always hold. The reset-pulse check also assumes that RST_CYC is shorter than the shortest tick period of 16 cycles, so that a pulse is never restarted in the middle. The bench keeps RST_CYC at 8.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // word addresses of the registers
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;
  localparam logic [1:0] A_ICLR = 2'd3;

  // control field positions (software decodes these)
  localparam int CB_RST  = 0;
  localparam int CB_IRQ  = 2;
  localparam int CB_DSEL = 3;
  localparam int CB_RUN  = 5;
  localparam int CB_PSC  = 8;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int BUS_W   = 16,
  parameter int CNT_W   = 16,
  parameter int PSC_W   = 8,
  parameter int DSEL_W  = 2,
  parameter int RST_VAL = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [1:0]        addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt_q,
  output logic [BUS_W-1:0]  rdata,
  output logic              rst_en,
  output logic              irq_en,
  output logic              run,
  output logic [DSEL_W-1:0] dsel,
  output logic [PSC_W-1:0]  psc,
  output logic [CNT_W-1:0]  data_q,
  output logic              kick,
  output logic [CNT_W-1:0]  kick_val,
  output logic              iclr
);
  logic              rst_en_q, rst_en_d;
  logic              irq_en_q, irq_en_d;
  logic              run_q, run_d;
  logic [DSEL_W-1:0] dsel_q, dsel_d;
  logic [PSC_W-1:0]  psc_q, psc_d;
  logic [CNT_W-1:0]  data_r, data_d;
  logic              ctrl_we, data_we;

  assign ctrl_we  = wr && (addr == A_CTRL);
  assign data_we  = wr && (addr == A_DATA);
  assign kick     = wr && (addr == A_CNT);
  assign iclr     = wr && (addr == A_ICLR);
  assign kick_val = wdata[CNT_W-1:0];

  always_comb begin
    rst_en_d = rst_en_q;
    irq_en_d = irq_en_q;
    run_d    = run_q;
    dsel_d   = dsel_q;
    psc_d    = psc_q;
    data_d   = data_r;
    if (ctrl_we) begin
      rst_en_d = wdata[CB_RST];
      irq_en_d = wdata[CB_IRQ];
      dsel_d   = wdata[CB_DSEL +: DSEL_W];
      run_d    = wdata[CB_RUN];
      psc_d    = wdata[CB_PSC +: PSC_W];
    end
    if (data_we) begin
      data_d = wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_en_q <= 1'b1;
      irq_en_q <= 1'b0;
      run_q    <= 1'b0;
      dsel_q   <= '0;
      psc_q    <= '0;
    end else if (ctrl_we) begin
      rst_en_q <= rst_en_d;
      irq_en_q <= irq_en_d;
      run_q    <= run_d;
      dsel_q   <= dsel_d;
      psc_q    <= psc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_r <= CNT_W'(RST_VAL);
    end else if (data_we) begin
      data_r <= data_d;
    end
  end

  // read path, combinational, zero when idle
  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (addr)
        A_CTRL: begin
          rdata[CB_RST]             = rst_en_q;
          rdata[CB_IRQ]             = irq_en_q;
          rdata[CB_DSEL +: DSEL_W]  = dsel_q;
          rdata[CB_RUN]             = run_q;
          rdata[CB_PSC +: PSC_W]    = psc_q;
        end
        A_DATA:  rdata[CNT_W-1:0] = data_r;
        A_CNT:   rdata[CNT_W-1:0] = cnt_q;
        default: rdata = '0;
      endcase
    end
  end

  assign rst_en = rst_en_q;
  assign irq_en = irq_en_q;
  assign run    = run_q;
  assign dsel   = dsel_q;
  assign psc    = psc_q;
  assign data_q = data_r;
endmodule

// File: rtl/wdg_tick.sv
module wdg_tick #(
  parameter int PSC_W   = 8,
  parameter int DSEL_W  = 2,
  parameter int DIV_LOG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PSC_W-1:0]  psc,
  input  logic [DSEL_W-1:0] dsel,
  output logic              tick
);
  localparam int NSEL   = 1 << DSEL_W;
  localparam int DCNT_W = DIV_LOG + NSEL - 1;

  logic [PSC_W-1:0]  pcnt_q, pcnt_d;
  logic [DCNT_W-1:0] dcnt_q, dcnt_d;
  logic [DCNT_W-1:0] term_tbl [NSEL];
  logic              pre;

  // terminal count of the divider stage per select value
  for (genvar g = 0; g < NSEL; g++) begin : g_term
    assign term_tbl[g] = DCNT_W'((1 << (DIV_LOG + g)) - 1);
  end

  assign pre  = run && (pcnt_q >= psc);
  assign tick = pre && (dcnt_q >= term_tbl[dsel]);

  always_comb begin
    pcnt_d = pre ? '0 : pcnt_q + 1'b1;
    dcnt_d = (dcnt_q >= term_tbl[dsel]) ? '0 : dcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (run) begin
      pcnt_q <= pcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
    end else if (pre) begin
      dcnt_q <= dcnt_d;
    end
  end
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int CNT_W   = 16,
  parameter int RST_CYC = 8,
  parameter int RST_VAL = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             kick,
  input  logic [CNT_W-1:0] kick_val,
  input  logic [CNT_W-1:0] data_q,
  input  logic             irq_en,
  input  logic             rst_en,
  input  logic             iclr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire,
  output logic             irq_o,
  output logic             rst_req_o
);
  localparam int RC_W = $clog2(RST_CYC + 1);

  logic [CNT_W-1:0] cnt_r, cnt_d;
  logic             pend_q, pend_d;
  logic [RC_W-1:0]  rc_q, rc_d;
  logic             cnt_ce;

  assign expire = tick && !kick && (cnt_r == '0);
  assign cnt_ce = kick || tick;

  always_comb begin
    if (kick) begin
      cnt_d = kick_val;
    end else if (cnt_r == '0) begin
      cnt_d = data_q;
    end else begin
      cnt_d = cnt_r - 1'b1;
    end

    if (expire && irq_en) begin
      pend_d = 1'b1;
    end else if (iclr) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q;
    end

    if (expire && rst_en) begin
      rc_d = RC_W'(RST_CYC);
    end else if (rc_q != '0) begin
      rc_d = rc_q - 1'b1;
    end else begin
      rc_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r <= CNT_W'(RST_VAL);
    end else if (cnt_ce) begin
      cnt_r <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rc_q   <= '0;
    end else begin
      pend_q <= pend_d;
      rc_q   <= rc_d;
    end
  end

  assign cnt_q     = cnt_r;
  assign irq_o     = pend_q;
  assign rst_req_o = (rc_q != '0);
endmodule

// File: rtl/wdg_top.sv
module wdg_top #(
  parameter int BUS_W   = 16,
  parameter int CNT_W   = 16,
  parameter int PSC_W   = 8,
  parameter int DSEL_W  = 2,
  parameter int DIV_LOG = 4,
  parameter int RST_CYC = 8,
  parameter int RST_VAL = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq_o,
  output logic             rst_req_o
);
  logic [1:0]        rsync_q;
  logic              rst_core_n;
  logic              rst_en, irq_en, run, kick, iclr, tick, expire;
  logic [DSEL_W-1:0] dsel;
  logic [PSC_W-1:0]  psc;
  logic [CNT_W-1:0]  data_q, kick_val, cnt_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rsync_q[1];

  wdg_regs #(
    .BUS_W(BUS_W), .CNT_W(CNT_W), .PSC_W(PSC_W),
    .DSEL_W(DSEL_W), .RST_VAL(RST_VAL)
  ) u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .wr(bus_wr), .rd(bus_rd), .addr(bus_addr), .wdata(bus_wdata),
    .cnt_q(cnt_q), .rdata(bus_rdata),
    .rst_en(rst_en), .irq_en(irq_en), .run(run), .dsel(dsel), .psc(psc),
    .data_q(data_q), .kick(kick), .kick_val(kick_val), .iclr(iclr)
  );

  wdg_tick #(
    .PSC_W(PSC_W), .DSEL_W(DSEL_W), .DIV_LOG(DIV_LOG)
  ) u_tick (
    .clk(clk), .rst_n(rst_core_n),
    .run(run), .psc(psc), .dsel(dsel), .tick(tick)
  );

  wdg_count #(
    .CNT_W(CNT_W), .RST_CYC(RST_CYC), .RST_VAL(RST_VAL)
  ) u_count (
    .clk(clk), .rst_n(rst_core_n),
    .tick(tick), .kick(kick), .kick_val(kick_val), .data_q(data_q),
    .irq_en(irq_en), .rst_en(rst_en), .iclr(iclr),
    .cnt_q(cnt_q), .expire(expire), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk #(
  parameter int CNT_W   = 16,
  parameter int RST_CYC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             irq_en,
  input logic             rst_en,
  input logic             run,
  input logic             kick,
  input logic             iclr,
  input logic             expire,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] data_q,
  input logic [CNT_W-1:0] kick_val
);
  localparam int SF_W = $clog2(RST_CYC + 1);
  logic [SF_W-1:0] since_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_fire <= SF_W'(RST_CYC);
    end else if (expire && rst_en) begin
      since_fire <= '0;
    end else if (since_fire < SF_W'(RST_CYC)) begin
      since_fire <= since_fire + 1'b1;
    end
  end

  // R6
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(irq_en && expire));
  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iclr && !expire) |=> !irq_o);
  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !kick) |=> $stable(cnt_q));
  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!kick && !expire) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));
  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == $past(data_q)));
  // R5
  kick_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == $past(kick_val)));
  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o == (since_fire < SF_W'(RST_CYC)));
endmodule

bind wdg_top wdg_chk #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .irq_o(irq_o), .rst_req_o(rst_req_o),
  .irq_en(irq_en), .rst_en(rst_en), .run(run), .kick(kick), .iclr(iclr),
  .expire(expire), .cnt_q(cnt_q), .data_q(data_q), .kick_val(kick_val)
);

// File: tb/sim_wdg_top.sv
`timescale 1ns/1ps
module sim_wdg_top;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        irq_o, rst_req_o;

  int checks = 0, failures = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  int m_run, m_irqen, m_rsten, m_dsel, m_psc, m_data, m_cnt, m_pend, m_rcnt, m_pcnt, m_dcnt;

  wdg_top #(.RST_CYC(RST_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ctrl_word(int psc, int run, int dsel, int ie, int re);
    return (psc << 8) | (run << 5) | (dsel << 3) | (ie << 2) | re;
  endfunction

  // reference model, one step per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_irqen = 0; m_rsten = 1; m_dsel = 0; m_psc = 0;
      m_data = 16'h8000; m_cnt = 16'h8000; m_pend = 0; m_rcnt = 0;
      m_pcnt = 0; m_dcnt = 0;
    end else begin
      int term, n_cnt, n_pend, n_rcnt, n_pcnt, n_dcnt;
      bit pre, tk, kk, ex, clr;
      term = (1 << (4 + m_dsel)) - 1;
      pre  = (m_run != 0) && (m_pcnt >= m_psc);
      tk   = pre && (m_dcnt >= term);
      kk   = bus_wr && (bus_addr == 2'd2);
      clr  = bus_wr && (bus_addr == 2'd3);
      ex   = tk && !kk && (m_cnt == 0);
      n_pcnt = m_run != 0 ? (pre ? 0 : m_pcnt + 1) : m_pcnt;
      n_dcnt = pre ? ((m_dcnt >= term) ? 0 : m_dcnt + 1) : m_dcnt;
      if (kk) n_cnt = bus_wdata;
      else if (tk) n_cnt = (m_cnt == 0) ? m_data : m_cnt - 1;
      else n_cnt = m_cnt;
      n_pend = (ex && m_irqen != 0) ? 1 : (clr ? 0 : m_pend);
      n_rcnt = (ex && m_rsten != 0) ? RST_CYC : (m_rcnt > 0 ? m_rcnt - 1 : 0);
      if (bus_wr && bus_addr == 2'd0) begin
        m_rsten = bus_wdata[0]; m_irqen = bus_wdata[2]; m_dsel = bus_wdata[4:3];
        m_run = bus_wdata[5]; m_psc = bus_wdata[15:8];
      end
      if (bus_wr && bus_addr == 2'd1) m_data = bus_wdata;
      m_cnt = n_cnt; m_pend = n_pend; m_rcnt = n_rcnt; m_pcnt = n_pcnt; m_dcnt = n_dcnt;
    end
  end

  // per-clock comparison of the outputs
  always @(negedge clk) begin
    if (chk_on && !done) begin
      check(irq_o == (m_pend != 0), "R6 irq_o vs model", irq_o, m_pend);
      check(rst_req_o == (m_rcnt > 0), "R7 rst_req_o vs model", rst_req_o, m_rcnt > 0);
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input string req, output int val);
    int exp;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    case (a)
      2'd0: exp = ctrl_word(m_psc, m_run, m_dsel, m_irqen, m_rsten);
      2'd1: exp = m_data;
      2'd2: exp = m_cnt;
      default: exp = 0;
    endcase
    val = bus_rdata;
    check(bus_rdata == exp[15:0], req, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int v, v2;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    chk_on = 1'b1;

    // R1 reset state
    check(irq_o == 1'b0 && rst_req_o == 1'b0, "R1 outputs low", {irq_o, rst_req_o}, 0);
    bus_read(2'd0, "R1 control reset", v);
    check(v == 16'h0001, "R1 control literal", v, 16'h0001);
    bus_read(2'd1, "R1 reload reset", v);
    check(v == 16'h8000, "R1 reload literal", v, 16'h8000);
    bus_read(2'd2, "R1 count reset", v);

    // R2 reserved control bits read zero
    bus_write(2'd0, 16'hFFC2);
    bus_read(2'd0, "R2 reserved bits", v);
    check(v == 16'hFF00, "R2 control readback", v, 16'hFF00);

    // R3 R4 R6 R7 fastest tick, short reload, both enables
    bus_write(2'd1, 16'd3);
    bus_write(2'd2, 16'd3);
    bus_write(2'd0, ctrl_word(0, 1, 0, 1, 1));
    for (int i = 0; i < 10; i++) begin
      idle(17);
      bus_read(2'd2, "R3 R4 count progress", v);
    end
    // R6 clear by any data
    bus_write(2'd3, 16'h1234);
    check(irq_o == 1'b0 || m_pend != 0, "R6 cleared", irq_o, 0);
    idle(70);
    bus_write(2'd3, 16'h0000);

    // R9 read of clear word returns zero, registers untouched
    bus_read(2'd3, "R9 clear word reads zero", v);
    bus_read(2'd1, "R9 reload untouched", v);
    check(v == 3, "R9 reload literal", v, 3);

    // R3 prescale 2, select 1: 96 clocks per tick
    bus_write(2'd1, 16'd1);
    bus_write(2'd0, ctrl_word(2, 1, 1, 1, 1));
    for (int i = 0; i < 8; i++) begin
      idle(60);
      bus_read(2'd2, "R3 prescaled count", v);
    end
    bus_write(2'd3, 16'hFFFF);

    // R8 freeze
    bus_write(2'd0, ctrl_word(2, 0, 1, 1, 1));
    bus_read(2'd2, "R8 frozen count a", v);
    idle(150);
    bus_read(2'd2, "R8 frozen count b", v2);
    check(v == v2, "R8 count held", v2, v);
    bus_write(2'd0, ctrl_word(2, 1, 1, 1, 1));
    idle(200);
    bus_read(2'd2, "R8 resumed count", v);

    // R5 repeated kicks keep it from expiring
    bus_write(2'd3, 16'd0);
    bus_write(2'd0, ctrl_word(0, 1, 0, 1, 1));
    for (int i = 0; i < 12; i++) begin
      bus_write(2'd2, 16'd4);
      idle(40);
      check(irq_o == 1'b0 && rst_req_o == 1'b0, "R5 kicked, no expiry", {irq_o, rst_req_o}, 0);
    end
    bus_read(2'd2, "R5 count after kicks", v);

    // R10 expiry with both enables clear
    bus_write(2'd1, 16'd0);
    bus_write(2'd0, ctrl_word(0, 1, 3, 0, 0));
    for (int i = 0; i < 6; i++) begin
      idle(100);
      check(irq_o == 1'b0 && rst_req_o == 1'b0, "R10 silent expiry", {irq_o, rst_req_o}, 0);
      bus_read(2'd2, "R10 count reloads", v);
    end

    // R7 reset only, interrupt disabled
    bus_write(2'd0, ctrl_word(0, 1, 0, 0, 1));
    idle(200);
    check(irq_o == 1'b0, "R7 no irq when disabled", irq_o, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule